// File: doc/BRIEF.md
# Two-Stage 1:16 Serial-to-Parallel Converter

This block turns one serial bit stream into 16-bit parallel words. It works as a tree of two 1:4 stages. The first stage splits the serial input into four lanes, and each lane runs at a quarter of the bit rate. The second stage is built from four identical 1:4 units, one for each lane, and it widens the four lanes into sixteen. The same second stage serves every input rate, because it only ever sees quarter-rate lanes.

Every 1:4 unit is a fixed seven-flop cell. Four flops sample its input on the four quarter-rate phases. Three more flops re-time the first three samples, so that all four outputs change together on the last phase. The model runs on a single bit-rate clock. A shared phase counter stands in for the four quadrature sampling clocks, and a small control module drives one-hot capture strobes into the datapath. An alignment input lets the system mark the bit that starts a word.

Top module: `deser16_tree`

## Requirements
- R1: Each output word holds 16 consecutive serial bits. Bit 15 is the earliest bit received and bit 0 is the latest.
- R2: `wordValid` is high in the second cycle after the cycle that carries a word's last serial bit. That is 17 cycles after the cycle that carries the word's first bit.
- R3: `wordValid` is a single-cycle pulse. In continuous operation it recurs exactly once every 16 cycles.
- R4: The bit present in a cycle where `alignStrobe` is high becomes bit 15 of a new word. The partial word in progress is discarded and gives no pulse. The next pulse comes 17 cycles after the strobe cycle.
- R5: Synchronous reset clears the capture flops and the phase counter. While `rst` is high and after it has been applied, `wordOut` is 0 and `wordValid` is 0. The first bit after reset release starts a word, and no pulse comes until a full 16-bit group has been taken.
- R6: Once the first word after reset or alignment is out, `wordOut` holds its value from one valid pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data input |
| alignStrobe | input | 1 | Marks the current bit as the first bit of a word |
| wordOut | output | 16 | Parallel word; bit 15 is the earliest bit |
| wordValid | output | 1 | One-cycle pulse when a new word is present |

## Verification
A PRBS-7 stream is compared word by word with a reference that the bench keeps from its own history of sent bits. Because a PRBS-7 stream does not repeat its words, any swap of lanes, groups or bit order shows up.

Fixed patterns give each lane and group a known signature, and errors at particular positions can be pinned down from it:
- a single walking one,
- a 1100 repetition,
- an asymmetric word.

Alignment strobes are applied mid-word, and one strobe is held for two cycles. These tests separate correct restart timing from a design that keeps the old phase or leaks a stale pulse. A reset in the middle of a word checks that the first word afterwards is complete and comes on time.

// File: rtl/deser16_pkg.sv
package deser16_pkg;
  localparam int RATIO  = 4;
  localparam int WORD_W = RATIO * RATIO;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int PH_W   = $clog2(RATIO);

  typedef struct packed {
    logic [RATIO-1:0] s1Cap;
    logic [RATIO-1:0] s2Cap;
  } deserStrobes_t;
endpackage

// File: rtl/deser_quad_unit.sv
module deser_quad_unit #(
  parameter int RATIO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [RATIO-1:0] capEn,
  output logic [RATIO-1:0] lanes
);
  logic [RATIO-1:0] sampleQ;
  logic [RATIO-2:0] retimeQ;

  for (genvar k = 0; k < RATIO; k++) begin : g_sample
    always_ff @(posedge clk) begin
      if (rst)           sampleQ[k] <= 1'b0;
      else if (capEn[k]) sampleQ[k] <= din;
    end
  end

  for (genvar k = 0; k < RATIO - 1; k++) begin : g_retime
    always_ff @(posedge clk) begin
      if (rst)                 retimeQ[k] <= 1'b0;
      else if (capEn[RATIO-1]) retimeQ[k] <= sampleQ[k];
    end
    assign lanes[k] = retimeQ[k];
  end
  assign lanes[RATIO-1] = sampleQ[RATIO-1];

  // R6: outputs move only after a last-phase strobe
  assert_lanes_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(capEn[RATIO-1]) |-> $stable(lanes));
endmodule

// File: rtl/deser16_ctrl.sv
module deser16_ctrl
  import deser16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          alignStrobe,
  output deserStrobes_t stb,
  output logic          wordValid
);
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] effCnt;
  logic [PH_W-1:0]  prevGroup;
  logic             primed;

  assign effCnt    = alignStrobe ? '0 : bitCnt;
  assign prevGroup = effCnt[CNT_W-1:PH_W] - PH_W'(1);

  always_comb begin
    stb = '0;
    stb.s1Cap[effCnt[PH_W-1:0]] = 1'b1;
    if (effCnt[PH_W-1:0] == '0) stb.s2Cap[prevGroup] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt    <= '0;
      primed    <= 1'b0;
      wordValid <= 1'b0;
    end else begin
      bitCnt    <= effCnt + CNT_W'(1);
      primed    <= (effCnt == CNT_W'(WORD_W - 1)) | (primed & ~alignStrobe);
      wordValid <= primed & ~alignStrobe & (effCnt == '0);
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);
  assert_valid_phase_R2: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> bitCnt == CNT_W'(1));
  assert_align_kills_R4: assert property (@(posedge clk) disable iff (rst)
    alignStrobe |=> !wordValid);
  assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wordValid);
endmodule

// File: rtl/deser16_datapath.sv
module deser16_datapath
  import deser16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  deserStrobes_t     stb,
  output logic [WORD_W-1:0] wordOut
);
  logic [RATIO-1:0] s1Lanes;
  logic [RATIO-1:0] s2Lanes [RATIO];

  deser_quad_unit #(.RATIO(RATIO)) uStage1 (
    .clk(clk), .rst(rst), .din(serIn), .capEn(stb.s1Cap), .lanes(s1Lanes)
  );

  for (genvar j = 0; j < RATIO; j++) begin : g_stage2
    deser_quad_unit #(.RATIO(RATIO)) uStage2 (
      .clk(clk), .rst(rst), .din(s1Lanes[j]), .capEn(stb.s2Cap),
      .lanes(s2Lanes[j])
    );
  end

  // serial index RATIO*k+j lands in unit j, lane k; index 0 goes to the MSB
  always_comb begin
    wordOut = '0;
    for (int j = 0; j < RATIO; j++)
      for (int k = 0; k < RATIO; k++)
        wordOut[WORD_W-1-(RATIO*k+j)] = s2Lanes[j][k];
  end
endmodule

// File: rtl/deser16_tree.sv
module deser16_tree
  import deser16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              alignStrobe,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  deserStrobes_t stb;

  deser16_ctrl uCtrl (
    .clk(clk), .rst(rst), .alignStrobe(alignStrobe), .stb(stb),
    .wordValid(wordValid)
  );

  deser16_datapath uData (
    .clk(clk), .rst(rst), .serIn(serIn), .stb(stb), .wordOut(wordOut)
  );
endmodule

// File: tb/deser16_tree_test.sv
`timescale 1ns/1ps
module deser16_tree_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0;
  logic alignStrobe = 1'b0;
  logic [15:0] wordOut;
  logic wordValid;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int startCyc = 0;
  bit byAlign = 1'b0;
  bit rstPending = 1'b0;
  bit finished = 1'b0;
  logic [63:0] hist = '0;
  logic [15:0] lastWord = '0;
  logic [6:0] prbs = 7'h7F;

  always #2.5 clk = ~clk;

  deser16_tree uut (
    .clk(clk), .rst(rst), .serIn(serIn), .alignStrobe(alignStrobe),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // one bit cycle: check outputs against the model, then drive the next bit
  task automatic step(input logic b, input logic al);
    int rel;
    bit expV;
    @(negedge clk);
    if (rstPending) begin
      rst = 1'b0; startCyc = cyc; byAlign = 1'b0; rstPending = 1'b0;
    end
    rel  = cyc - startCyc;
    expV = (rel >= 17) && (((rel - 17) % 16) == 0);
    check(expV ? "R2" : "R3", wordValid === expV, {31'd0, wordValid}, {31'd0, expV});
    if (expV) begin
      check(byAlign ? "R4" : "R1", wordOut === hist[16:1], {16'd0, wordOut},
            {16'd0, hist[16:1]});
      lastWord = wordOut;
    end else if (rel >= 18) begin
      check("R6", wordOut === lastWord, {16'd0, wordOut}, {16'd0, lastWord});
    end
    if (al) begin startCyc = cyc; byAlign = 1'b1; end
    serIn = b; alignStrobe = al;
    hist = {hist[62:0], b};
    cyc++;
  endtask

  task automatic nextPrbs(output logic b);
    b = prbs[6] ^ prbs[5];
    prbs = {prbs[5:0], b};
  endtask

  task automatic doReset(input int n);
    @(negedge clk);
    rst = 1'b1; serIn = 1'b0; alignStrobe = 1'b0; cyc++;
    for (int i = 1; i < n; i++) begin @(negedge clk); cyc++; end
    @(negedge clk);
    check("R5", wordOut === 16'h0 && wordValid === 1'b0, {15'd0, wordValid, wordOut}, 32'h0);
    cyc++;
    rstPending = 1'b1;
  endtask

  task automatic testResetState();
    doReset(3);
  endtask

  task automatic testPrbsStream(input int nWords);
    logic b;
    for (int i = 0; i < nWords * 16 + 2; i++) begin nextPrbs(b); step(b, 1'b0); end
  endtask

  task automatic testFixedPatterns();
    logic [15:0] pats [4] = '{16'h8000, 16'hCCCC, 16'hA5C3, 16'h0001};
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 3; r++)
        for (int i = 15; i >= 0; i--) step(pats[p][i], 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0);
  endtask

  task automatic testAlign();
    logic b;
    for (int i = 0; i < 7; i++) begin nextPrbs(b); step(b, 1'b0); end
    nextPrbs(b); step(b, 1'b1);
    for (int i = 0; i < 50; i++) begin nextPrbs(b); step(b, 1'b0); end
    nextPrbs(b); step(b, 1'b1);
    nextPrbs(b); step(b, 1'b1);
    for (int i = 0; i < 40; i++) begin nextPrbs(b); step(b, 1'b0); end
  endtask

  task automatic testResetMidWord();
    logic b;
    for (int i = 0; i < 9; i++) begin nextPrbs(b); step(b, 1'b0); end
    doReset(2);
    for (int i = 0; i < 50; i++) begin nextPrbs(b); step(b, 1'b0); end
  endtask

  initial begin
    testResetState();
    testPrbsStream(20);
    testFixedPatterns();
    testAlign();
    testResetMidWord();
    testPrbsStream(8);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule